// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block divides one 32-bit operand by another over a fixed number of clock cycles and returns either the quotient or the remainder. Three independent select bits chosen with the start command decide the operation: whether the operands are treated as two's-complement or as unsigned numbers, whether the quotient or the remainder is returned, and whether the divisor comes from a 32-bit register operand or from a 16-bit immediate field. Together the three bits give eight operations.

Signed division truncates toward zero, and the remainder carries the sign of the dividend. A 16-bit immediate divisor is sign-extended for signed operations and zero-extended for unsigned ones. A zero divisor produces no result. Instead the unit raises a divide-fault flag together with its completion pulse one cycle after the start, and the surrounding pipeline turns that flag into an exception. Internally the unit runs a restoring shift-subtract loop on operand magnitudes and applies the signs in a final step.

Top module: `int_divider`

## Requirements
- R1: After a synchronous active-low reset, busy, done and fault are 0 and result is 0. A reset that arrives during an operation cancels it, and no done pulse follows.
- R2: With op_signed=0 and op_imm=0, the block returns dividend / divisor_reg when op_rem=0, and dividend % divisor_reg when op_rem=1. Both operands are unsigned 32-bit values.
- R3: With op_signed=1, the quotient is truncated toward zero and the remainder has the sign of the dividend, so that dividend = quotient*divisor + remainder.
- R4: With op_imm=1 and op_signed=1, the divisor is imm sign-extended to 32 bits, and divisor_reg is ignored.
- R5: With op_imm=1 and op_signed=0, the divisor is imm zero-extended to 32 bits.
- R6: If the selected divisor is zero, the block does not go busy. In the cycle after the start it raises done and fault together and drives result to 0.
- R7: A signed division of 0x80000000 by -1 gives a quotient of 0x80000000 and a remainder of 0, without a fault.
- R8: For a non-zero divisor, busy is high for exactly 33 cycles after the start edge. done pulses for one cycle, in the 34th cycle after the start edge, with fault at 0.
- R9: A start while busy is high is ignored. The running operation completes with its own operands, and the ignored start produces no done pulse.
- R10: fault is only ever high together with done, and done is never high while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins an operation when the unit is idle |
| op_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_rem | input | 1 | 1 = return remainder, 0 = return quotient |
| op_imm | input | 1 | 1 = divisor from imm, 0 = divisor from divisor_reg |
| dividend | input | 32 | Dividend |
| divisor_reg | input | 32 | Register divisor |
| imm | input | 16 | Immediate divisor field |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Quotient or remainder, valid with done |
| fault | output | 1 | Divide by zero, valid with done |

## Verification
The operand patterns are chosen to separate the operation variants from one another:
- Unsigned cases with the top bit set separate an unsigned divide from a signed one.
- Each sign combination of dividend and divisor checks truncation toward zero and the sign of the remainder.
- An immediate of 0xFFFF or 0x8000 gives a different divisor depending on whether it is sign-extended or zero-extended.
- A zero register divisor and a zero immediate, with a non-zero register value present, show that the zero test looks at the selected divisor.
- The most negative dividend divided by -1 covers the one signed overflow case.

Directed sequences cover a start issued while the unit is busy and a reset in the middle of an operation.

// File: rtl/intdiv_pkg.sv
// Shared types for the iterative divider.
// Assumes: consumers import the package; no parameters live here.
package intdiv_pkg;

    // Operation select bits captured at start.
    typedef struct packed {
        logic is_signed;
        logic want_rem;
        logic use_imm;
    } div_op_t;

    // Controller states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_t;

endpackage

// File: rtl/intdiv_prep.sv
// Operand preparation: picks the divisor, tests it for zero and
// converts both operands to magnitudes with their sign flags.
// Assumes: purely combinational; IW < DW.
module intdiv_prep
    import intdiv_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = 16
) (
    input  div_op_t          op,
    input  logic [DW-1:0]    dividend,
    input  logic [DW-1:0]    divisor_reg,
    input  logic [IW-1:0]    imm,
    output logic [DW-1:0]    mag_a,
    output logic [DW-1:0]    mag_b,
    output logic             neg_quo,
    output logic             neg_rem,
    output logic             div_zero
);
    localparam int XW = DW - IW;

    logic [DW-1:0] imm_sx;
    logic [DW-1:0] imm_zx;
    logic [DW-1:0] dvs;
    logic          sgn_a;
    logic          sgn_b;

    // Extend the immediate both ways and select the divisor.
    always_comb begin
        imm_sx = {{XW{imm[IW-1]}}, imm};
        imm_zx = {{XW{1'b0}}, imm};
        if (op.use_imm)
            dvs = op.is_signed ? imm_sx : imm_zx;
        else
            dvs = divisor_reg;
    end

    // Zero test: immediate forms test the sign-extended value.
    always_comb begin
        if (op.use_imm)
            div_zero = (imm_sx == '0);
        else
            div_zero = (divisor_reg == '0);
    end

    // Magnitudes and result sign flags.
    always_comb begin
        sgn_a   = op.is_signed & dividend[DW-1];
        sgn_b   = op.is_signed & dvs[DW-1];
        mag_a   = sgn_a ? (~dividend + 1'b1) : dividend;
        mag_b   = sgn_b ? (~dvs + 1'b1) : dvs;
        neg_quo = sgn_a ^ sgn_b;
        neg_rem = sgn_a;
    end
endmodule

// File: rtl/intdiv_core.sv
// Restoring shift-subtract datapath on unsigned magnitudes.
// One quotient bit per step; DW steps give a full result.
// Assumes: load and step are never high together.
module intdiv_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] mag_a,
    input  logic [DW-1:0] mag_b,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem
);
    logic [DW-1:0] dvs_q;
    logic [DW:0]   shifted;
    logic [DW:0]   trial;

    // Trial subtraction of the divisor from the shifted remainder.
    always_comb begin
        shifted = {rem, quo[DW-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    // Iteration registers: load operands, then shift in quotient bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo   <= '0;
            rem   <= '0;
            dvs_q <= '0;
        end else if (load) begin
            quo   <= mag_a;
            rem   <= '0;
            dvs_q <= mag_b;
        end else if (step) begin
            if (!trial[DW]) begin
                rem <= trial[DW-1:0];
                quo <= {quo[DW-2:0], 1'b1};
            end else begin
                rem <= shifted[DW-1:0];
                quo <= {quo[DW-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/intdiv_fixup.sv
// Sign fix-up and result selection after the magnitude loop.
// Assumes: purely combinational; flags come from the captured operation.
module intdiv_fixup #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] quo,
    input  logic [DW-1:0] rem,
    input  logic          neg_quo,
    input  logic          neg_rem,
    input  logic          want_rem,
    output logic [DW-1:0] value
);
    logic [DW-1:0] q_s;
    logic [DW-1:0] r_s;

    // Negate where needed, then choose quotient or remainder.
    always_comb begin
        q_s   = neg_quo ? (~quo + 1'b1) : quo;
        r_s   = neg_rem ? (~rem + 1'b1) : rem;
        value = want_rem ? r_s : q_s;
    end
endmodule

// File: rtl/int_divider.sv
// Top of the iterative divide/remainder unit. Accepts a start when idle,
// faults immediately on a zero divisor, otherwise runs DW iterations plus
// one fix-up cycle and pulses done with the result.
// Assumes: start is sampled only while idle; outputs are registered.
module int_divider
    import intdiv_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_signed,
    input  logic          op_rem,
    input  logic          op_imm,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor_reg,
    input  logic [IW-1:0] imm,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result,
    output logic          fault
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    div_state_t    state;
    logic [CW-1:0] iter;
    div_op_t       op_in;
    logic          keep_rem;
    logic          keep_nq;
    logic          keep_nr;
    logic [DW-1:0] mag_a;
    logic [DW-1:0] mag_b;
    logic          neg_quo;
    logic          neg_rem;
    logic          div_zero;
    logic          accept;
    logic          do_load;
    logic [DW-1:0] quo;
    logic [DW-1:0] rem;
    logic [DW-1:0] fix_val;
    logic          done_q;
    logic          fault_q;
    logic [DW-1:0] result_q;

    // Bundle the select bits and derive the accept/load strobes.
    always_comb begin
        op_in   = '{is_signed: op_signed, want_rem: op_rem, use_imm: op_imm};
        accept  = (state == ST_IDLE) && start;
        do_load = accept && !div_zero;
    end

    intdiv_prep #(.DW(DW), .IW(IW)) u_prep (
        .op          (op_in),
        .dividend    (dividend),
        .divisor_reg (divisor_reg),
        .imm         (imm),
        .mag_a       (mag_a),
        .mag_b       (mag_b),
        .neg_quo     (neg_quo),
        .neg_rem     (neg_rem),
        .div_zero    (div_zero)
    );

    intdiv_core #(.DW(DW)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (do_load),
        .step  (state == ST_RUN),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .quo   (quo),
        .rem   (rem)
    );

    intdiv_fixup #(.DW(DW)) u_fix (
        .quo      (quo),
        .rem      (rem),
        .neg_quo  (keep_nq),
        .neg_rem  (keep_nr),
        .want_rem (keep_rem),
        .value    (fix_val)
    );

    // Controller: sequencing, captured flags and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            iter     <= '0;
            keep_rem <= 1'b0;
            keep_nq  <= 1'b0;
            keep_nr  <= 1'b0;
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            result_q <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (div_zero) begin
                            done_q   <= 1'b1;
                            fault_q  <= 1'b1;
                            result_q <= '0;
                        end else begin
                            state    <= ST_RUN;
                            iter     <= '0;
                            keep_rem <= op_rem;
                            keep_nq  <= neg_quo;
                            keep_nr  <= neg_rem;
                        end
                    end
                end
                ST_RUN: begin
                    iter <= iter + 1'b1;
                    if (iter == LAST)
                        state <= ST_FIN;
                end
                ST_FIN: begin
                    result_q <= fix_val;
                    done_q   <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the ports from the registered state.
    always_comb begin
        busy   = (state != ST_IDLE);
        done   = done_q;
        fault  = fault_q;
        result = result_q;
    end
endmodule

// File: rtl/int_divider_checker.sv
// Port-level protocol checker for int_divider, attached by bind.
// Assumes: synchronous active-low reset; observes ports only.
module int_divider_checker #(
    parameter int DW = 32,
    parameter int IW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          op_signed,
    input logic          op_imm,
    input logic [DW-1:0] divisor_reg,
    input logic [IW-1:0] imm,
    input logic          busy,
    input logic          done,
    input logic          fault,
    input logic [DW-1:0] result
);
    localparam int BW = $clog2(DW + 2) + 1;

    logic [BW-1:0] busy_cnt;
    logic          zero_sel;

    // Selected divisor is zero, seen from the ports.
    always_comb begin
        zero_sel = op_imm ? (imm == '0) : (divisor_reg == '0);
    end

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= '0;
        else                 busy_cnt <= busy_cnt + 1'b1;
    end

    assert_fault_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_zero_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && zero_sel) |=> (done && fault && result == '0 && !busy));

    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (busy_cnt == BW'(DW + 1)));
endmodule

bind int_divider int_divider_checker #(.DW(DW), .IW(IW)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_signed   (op_signed),
    .op_imm      (op_imm),
    .divisor_reg (divisor_reg),
    .imm         (imm),
    .busy        (busy),
    .done        (done),
    .fault       (fault),
    .result      (result)
);

// File: tb/test_int_divider.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, busy-time starts and done pulse width.
module test_int_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_signed = 1'b0;
    logic        op_rem = 1'b0;
    logic        op_imm = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor_reg = '0;
    logic [15:0] imm = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;
    logic        fault;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    int_divider i_int_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .op_signed(op_signed),
        .op_rem(op_rem), .op_imm(op_imm), .dividend(dividend),
        .divisor_reg(divisor_reg), .imm(imm), .busy(busy), .done(done),
        .result(result), .fault(fault)
    );

    localparam int N = 17;
    // Per row: dividend, register divisor, immediate, {signed, rem, imm}.
    localparam logic [31:0] TA [N] = '{
        32'd100, 32'd100, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFF9,
        32'd7, 32'd7, 32'd1000, 32'hFFFF_FC18, 32'h0002_0000,
        32'h0001_2345, 32'h8000_0000, 32'h8000_0000, 32'd5, 32'd5,
        32'd5, 32'h8000_0000};
    localparam logic [31:0] TB [N] = '{
        32'd7, 32'd7, 32'd10, 32'd2, 32'd2,
        32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'd3, 32'd3, 32'd0,
        32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'h0000_1234,
        32'h0000_1234, 32'd0};
    localparam logic [15:0] TI [N] = '{
        16'd0, 16'd0, 16'd0, 16'd0, 16'd0,
        16'd0, 16'd0, 16'hFFF6, 16'hFFFD, 16'hFFFF,
        16'h8000, 16'd0, 16'd0, 16'd0, 16'd0,
        16'd0, 16'hFFFF};
    localparam logic [2:0] TF [N] = '{
        3'b000, 3'b010, 3'b000, 3'b100, 3'b110,
        3'b100, 3'b110, 3'b101, 3'b111, 3'b001,
        3'b011, 3'b100, 3'b110, 3'b000, 3'b101,
        3'b011, 3'b101};
    string row_tag [N] = '{
        "R2", "R2", "R2", "R3", "R3",
        "R3", "R3", "R4", "R4", "R5",
        "R5", "R7", "R7", "R6", "R6",
        "R6", "R7"};

    // Reference model from the requirements: {fault, value}.
    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [15:0] im, input logic [2:0] f);
        logic [31:0] dv;
        logic [31:0] q;
        logic [31:0] r;
        if (f[0]) dv = f[2] ? {{16{im[15]}}, im} : {16'h0, im};
        else      dv = b;
        if (dv == 0) return {1'b1, 32'h0};
        if (f[2]) begin
            if (a == 32'h8000_0000 && dv == 32'hFFFF_FFFF) begin
                q = 32'h8000_0000; r = 32'h0;
            end else begin
                q = $signed(a) / $signed(dv);
                r = $signed(a) % $signed(dv);
            end
        end else begin
            q = a / dv;
            r = a % dv;
        end
        return {1'b0, f[1] ? r : q};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Issue one start (inputs set at a negedge) and count negedges to done.
    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [2:0] f, output int lat);
        @(negedge clk);
        dividend = a; divisor_reg = b; imm = im;
        op_signed = f[2]; op_rem = f[1]; op_imm = f[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lat;
        logic [32:0] exp;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1", "busy at reset", {31'h0, busy}, 32'h0);
        check("R1", "done at reset", {31'h0, done}, 32'h0);
        check("R1", "fault at reset", {31'h0, fault}, 32'h0);
        check("R1", "result at reset", result, 32'h0);
        rst_n = 1'b1;

        // Vector table walk.
        for (int k = 0; k < N; k++) begin
            exp = model(TA[k], TB[k], TI[k], TF[k]);
            issue(TA[k], TB[k], TI[k], TF[k], lat);
            check(row_tag[k], "fault", {31'h0, fault}, {31'h0, exp[32]});
            check(row_tag[k], "result", result, exp[31:0]);
            // R8: latency 34 cycles, R6: 1 cycle on fault.
            check(exp[32] ? "R6" : "R8", "latency", lat, exp[32] ? 32'd1 : 32'd34);
            @(negedge clk);
            // R10: done is a single-cycle pulse.
            check("R10", "done after pulse", {31'h0, done}, 32'h0);
        end

        // R9: start while busy is ignored.
        @(negedge clk);
        dividend = 32'd1000; divisor_reg = 32'd10; imm = 16'h0;
        op_signed = 1'b0; op_rem = 1'b0; op_imm = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        dividend = 32'd9; divisor_reg = 32'd0; op_rem = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9", "busy kept", {31'h0, busy}, 32'h1);
        check("R9", "no fault from ignored start", {31'h0, fault}, 32'h0);
        lat = 6;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check("R9", "first op result", result, 32'd100);
        check("R9", "first op latency", lat, 32'd34);
        begin
            int extra = 0;
            @(negedge clk);
            for (int c = 0; c < 40; c++) begin
                if (done || busy) extra++;
                @(negedge clk);
            end
            check("R9", "no second completion", extra, 32'd0);
        end

        // R1: reset mid-operation cancels it.
        @(negedge clk);
        dividend = 32'd77; divisor_reg = 32'd7; op_rem = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "busy after mid reset", {31'h0, busy}, 32'h0);
        check("R1", "result after mid reset", result, 32'h0);
        begin
            int seen = 0;
            for (int c = 0; c < 40; c++) begin
                if (done) seen++;
                @(negedge clk);
            end
            check("R1", "no done after mid reset", seen, 32'd0);
        end

        finish_run();
    end
endmodule